// File: doc/BRIEF.md
# NOR flash command interpreter

This block sits behind the write port of a two-bank NOR flash model. It watches single-cycle bus writes and recognises keyed command sequences. Each command opens with two unlock writes at fixed addresses. The sequences cover word or byte program, sector erase, chip erase, a bypass mode for fast repeated programming, an identification (autoselect) mode, reset, and suspend/resume of a sector erase. A small flop-based array stands in for the flash cells. Each bank reports its own busy flag. While one bank runs an embedded operation, reads aimed at the other bank return array data in the same cycle.

Program and erase requests pass through a per-sector protection mask before they launch. Only one embedded operation runs at a time, except that a suspended sector erase leaves room for a program to another sector. Programming can only clear bits, and erasing sets a whole sector to all ones. Both take effect when the operation completes. A one-cycle pulse announces each program or erase launch to the status logic downstream.

Top module: `nor_cmd_interp`

## Requirements
- R1: After synchronous reset every word reads FFFFh in word mode and 00FFh in byte mode, both busy flags are 0, no start pulse is raised, and the decoder is in read mode.
- R2: A program takes four writes. The first three are AAh to 555h, 55h to 2AAh and A0h to 555h in word mode; byte mode uses AAAh, 555h and AAAh, and only the low data byte is compared. The fourth write carries the data, and the cell becomes old AND new. In byte mode the byte address has bit 0 as the lane (1 = upper byte), and a byte read returns the lane in bits 7:0 with zero above.
- R3: A program launches on the edge that samples its data write. `prog_start` is high for exactly that one cycle. The target bank's busy flag (the flag index is word-address bit 7) stays high for PROG_CYC cycles, and the new value can be read after it drops.
- R4: A sector erase takes six writes: unlock, 80h, unlock, then 30h to any address in the sector (sector = word-address bits 7:5). `erase_start` pulses for one cycle, the bank is busy for ERASE_CYC cycles, and then every word of the sector reads FFFFh.
- R5: The same six writes ending in 10h to the first unlock address start a chip erase. Both busy flags are high, and afterwards every unprotected sector reads FFFFh.
- R6: A program or sector erase aimed at a sector whose PROT_MASK bit is set is dropped. There is no start pulse, no busy flag, and the data is unchanged. A chip erase skips protected sectors.
- R7: While a bank is busy, reads of that bank return 0000h, and reads of the other bank return array data in the same cycle.
- R8: AAh, 55h and then 20h to 555h enter bypass mode. In bypass mode a program takes two writes (A0h, then the data). Writing 90h then 00h leaves bypass mode, after which A0h followed by data programs nothing.
- R9: AAh, 55h and then 90h to 555h enter autoselect mode. A read at in-sector word offset 2 (byte offset 4) then returns 0001h for a protected sector and 0000h otherwise. Other addresses read array data. F0h leaves the mode.
- R10: A write whose address or data does not match the next expected cycle drops the partial sequence and returns the decoder to read mode.
- R11: B0h at any address during a running sector erase suspends it. The busy flag drops on the next cycle, the bank reads array data, and the elapsed time is kept. 30h then resumes, and the bank stays busy for the remaining ERASE_CYC minus elapsed cycles. B0h has no effect during a chip erase.
- R12: F0h while an erase is suspended leaves the erase suspended, so a later 30h still resumes it.
- R13: While an erase is suspended, a program to another sector runs normally. A program to the suspended sector is dropped.
- R14: A program or erase sequence that completes while an embedded operation is running is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we | input | 1 | Write strobe, one bus write per high cycle |
| addr | input | ADDR_W | Word address, or byte address when byte_mode is high |
| wdata | input | 16 | Write data; commands use bits 7:0 |
| byte_mode | input | 1 | 1 selects byte addressing and byte data |
| rdata | output | 16 | Combinational read data for addr |
| bank_busy | output | 2 | Per-bank embedded-operation busy flags |
| prog_start | output | 1 | One-cycle pulse when a program launches |
| erase_start | output | 1 | One-cycle pulse when an erase launches |

## Verification
The bench uses the default build: a 256-word array in eight 32-word sectors, with sector 2 protected, PROG_CYC of 4 and ERASE_CYC of 16. At this size every word can be programmed in bypass mode with a pattern computed from its address, and each of the 256 words can be read back after every phase. The short timers let the bench count each busy window cycle by cycle, including the remaining time of an erase that was suspended after exactly four active cycles.

// File: rtl/nfc_pkg.sv
// Package: shared command codes and decoder state type for the NOR
// command interpreter. Assumes commands are carried in data bits 7:0.
package nfc_pkg;
    localparam logic [7:0] CMD_KEY1    = 8'hAA;
    localparam logic [7:0] CMD_KEY2    = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_SECT    = 8'h30;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_BYPASS  = 8'h20;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESUME  = 8'h30;
    localparam logic [7:0] CMD_BYP_END = 8'h00;

    typedef enum logic [3:0] {
        CS_READ,
        CS_KEY1,
        CS_KEY2,
        CS_PGM,
        CS_ER1,
        CS_ER2,
        CS_ER3,
        CS_BYP,
        CS_BYP_PGM,
        CS_BYP_EXIT
    } cmd_state_t;
endpackage

// File: rtl/nfc_decoder.sv
// Command decoder: tracks the multi-write key sequences and raises
// one-cycle requests (program, sector/chip erase, suspend, resume).
// Assumes ADDR_W >= 12 and that requests are qualified downstream.
module nfc_decoder
    import nfc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              byte_mode,
    output logic              req_prog,
    output logic              req_serase,
    output logic              req_cerase,
    output logic              req_susp,
    output logic              req_resume,
    output logic              autosel
);
    cmd_state_t state_q, state_d;
    logic       key1_adr, key2_adr;
    logic [7:0] cmd;
    logic       set_as, clr_as;

    assign cmd = wdata[7:0];

    // Match the two key addresses for the current addressing mode
    always_comb begin
        if (byte_mode) begin
            key1_adr = (addr[11:0] == 12'hAAA);
            key2_adr = (addr[11:0] == 12'h555);
        end else begin
            key1_adr = (addr[10:0] == 11'h555);
            key2_adr = (addr[10:0] == 11'h2AA);
        end
    end

    // Next-state and request generation for one bus write
    always_comb begin
        state_d    = state_q;
        req_prog   = 1'b0;
        req_serase = 1'b0;
        req_cerase = 1'b0;
        req_susp   = 1'b0;
        req_resume = 1'b0;
        set_as     = 1'b0;
        clr_as     = 1'b0;
        if (we) begin
            unique case (state_q)
                CS_READ: begin
                    if (cmd == CMD_KEY1 && key1_adr) state_d = CS_KEY1;
                    else begin
                        state_d    = CS_READ;
                        clr_as     = (cmd == CMD_RESET);
                        req_susp   = (cmd == CMD_SUSPEND);
                        req_resume = (cmd == CMD_RESUME);
                    end
                end
                CS_KEY1: begin
                    state_d = (cmd == CMD_KEY2 && key2_adr) ? CS_KEY2 : CS_READ;
                    clr_as  = (cmd == CMD_RESET);
                end
                CS_KEY2: begin
                    state_d = CS_READ;
                    clr_as  = (cmd == CMD_RESET);
                    if (key1_adr) begin
                        if (cmd == CMD_PROG)        state_d = CS_PGM;
                        else if (cmd == CMD_ERASE)  state_d = CS_ER1;
                        else if (cmd == CMD_BYPASS) state_d = CS_BYP;
                        else if (cmd == CMD_IDENT)  set_as  = 1'b1;
                    end
                end
                CS_PGM: begin
                    req_prog = 1'b1;
                    state_d  = CS_READ;
                end
                CS_ER1: begin
                    state_d = (cmd == CMD_KEY1 && key1_adr) ? CS_ER2 : CS_READ;
                    clr_as  = (cmd == CMD_RESET);
                end
                CS_ER2: begin
                    state_d = (cmd == CMD_KEY2 && key2_adr) ? CS_ER3 : CS_READ;
                    clr_as  = (cmd == CMD_RESET);
                end
                CS_ER3: begin
                    state_d    = CS_READ;
                    clr_as     = (cmd == CMD_RESET);
                    req_serase = (cmd == CMD_SECT);
                    req_cerase = (cmd == CMD_CHIP) && key1_adr;
                end
                CS_BYP: begin
                    if (cmd == CMD_PROG)       state_d = CS_BYP_PGM;
                    else if (cmd == CMD_IDENT) state_d = CS_BYP_EXIT;
                    else                       state_d = CS_BYP;
                end
                CS_BYP_PGM: begin
                    req_prog = 1'b1;
                    state_d  = CS_BYP;
                end
                CS_BYP_EXIT: begin
                    state_d = (cmd == CMD_BYP_END) ? CS_READ : CS_BYP;
                end
                default: state_d = CS_READ;
            endcase
        end
    end

    // Sequence state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_READ;
        else        state_q <= state_d;
    end

    // Autoselect mode flag: set by the ident command, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)      autosel <= 1'b0;
        else if (set_as) autosel <= 1'b1;
        else if (clr_as) autosel <= 1'b0;
    end

    // R9
    asel_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(autosel) |-> ($past(we) && $past(state_q) == CS_KEY2
                            && $past(wdata[7:0]) == CMD_IDENT));
endmodule

// File: rtl/nfc_engine.sv
// Embedded operation engine: qualifies requests against protection and
// the current activity, then times one program and one (suspendable)
// erase. Assumes the bank is the top word-address bit and the sector the
// top SECT_BITS bits; PROG_CYC and ERASE_CYC are at least 2.
module nfc_engine #(
    parameter int                         ARR_AW    = 8,
    parameter int                         SECT_BITS = 3,
    parameter logic [(1<<SECT_BITS)-1:0]  PROT_MASK = '0,
    parameter int                         PROG_CYC  = 4,
    parameter int                         ERASE_CYC = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_prog,
    input  logic                 req_serase,
    input  logic                 req_cerase,
    input  logic                 req_susp,
    input  logic                 req_resume,
    input  logic [ARR_AW-1:0]    tgt_idx,
    input  logic                 tgt_byte,
    input  logic                 tgt_lane,
    input  logic [15:0]          tgt_data,
    output logic                 prog_start,
    output logic                 erase_start,
    output logic [1:0]           bank_busy,
    output logic                 pg_fin,
    output logic [ARR_AW-1:0]    pg_idx,
    output logic [15:0]          pg_mask,
    output logic                 er_fin,
    output logic                 er_chip,
    output logic [SECT_BITS-1:0] er_sect
);
    localparam int PCW = $clog2(PROG_CYC + 1);
    localparam int ECW = $clog2(ERASE_CYC + 1);

    logic                 pg_act;
    logic [PCW-1:0]       pg_cnt;
    logic                 er_act, er_susp, er_run;
    logic [ECW-1:0]       er_cnt;
    logic [SECT_BITS-1:0] tsect;
    logic                 prog_ok, serase_ok, cerase_ok, susp_ok, resume_ok;
    logic [15:0]          new_mask;

    assign tsect  = tgt_idx[ARR_AW-1 -: SECT_BITS];
    assign er_run = er_act && !er_susp;
    assign pg_fin = pg_act && (pg_cnt == PCW'(PROG_CYC - 1));
    assign er_fin = er_run && (er_cnt == ECW'(ERASE_CYC - 1));

    // Request qualification against protection and ongoing work
    always_comb begin
        prog_ok   = req_prog && !pg_act && !er_run && !PROT_MASK[tsect]
                    && !(er_act && tsect == er_sect);
        serase_ok = req_serase && !pg_act && !er_act && !PROT_MASK[tsect];
        cerase_ok = req_cerase && !pg_act && !er_act;
        susp_ok   = req_susp && er_run && !er_chip && !er_fin;
        resume_ok = req_resume && er_act && er_susp && !pg_act;
    end

    // AND-mask for the program data in word or byte form
    always_comb begin
        if (!tgt_byte)     new_mask = tgt_data;
        else if (tgt_lane) new_mask = {tgt_data[7:0], 8'hFF};
        else               new_mask = {8'hFF, tgt_data[7:0]};
    end

    // Program timer and latched target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_act  <= 1'b0;
            pg_cnt  <= '0;
            pg_idx  <= '0;
            pg_mask <= '1;
        end else if (prog_ok) begin
            pg_act  <= 1'b1;
            pg_cnt  <= '0;
            pg_idx  <= tgt_idx;
            pg_mask <= new_mask;
        end else if (pg_fin) begin
            pg_act  <= 1'b0;
        end else if (pg_act) begin
            pg_cnt  <= pg_cnt + 1'b1;
        end
    end

    // Erase timer with suspend/resume; the count holds while suspended
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            er_act  <= 1'b0;
            er_susp <= 1'b0;
            er_chip <= 1'b0;
            er_sect <= '0;
            er_cnt  <= '0;
        end else if (serase_ok || cerase_ok) begin
            er_act  <= 1'b1;
            er_susp <= 1'b0;
            er_chip <= cerase_ok;
            er_sect <= tsect;
            er_cnt  <= '0;
        end else if (er_fin) begin
            er_act  <= 1'b0;
            er_susp <= 1'b0;
        end else begin
            if (er_run)    er_cnt  <= er_cnt + 1'b1;
            if (susp_ok)   er_susp <= 1'b1;
            if (resume_ok) er_susp <= 1'b0;
        end
    end

    // Launch pulses toward the status logic
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_start  <= 1'b0;
            erase_start <= 1'b0;
        end else begin
            prog_start  <= prog_ok;
            erase_start <= serase_ok || cerase_ok;
        end
    end

    // Per-bank busy from the two timers
    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_comb begin
            bank_busy[b] = (pg_act && pg_idx[ARR_AW-1] == 1'(b))
                        || (er_run && (er_chip || er_sect[SECT_BITS-1] == 1'(b)));
        end
    end

    // R14
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pg_act && er_run));
    // R11
    susp_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        er_susp |-> (er_act && !er_chip));
    // R3
    pstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> (pg_act && pg_cnt == '0));
    // R6
    prot_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !PROT_MASK[pg_idx[ARR_AW-1 -: SECT_BITS]]);
    // R4
    estart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> (er_act && !er_susp && er_cnt == '0));
endmodule

// File: rtl/nfc_array.sv
// Cell array stand-in: one 16-bit register per word, programmed by AND,
// erased per sector to all ones, reset to the erased state. The read
// path returns zero for a busy bank and protection bits in autoselect.
module nfc_array #(
    parameter int                         ARR_AW    = 8,
    parameter int                         SECT_BITS = 3,
    parameter logic [(1<<SECT_BITS)-1:0]  PROT_MASK = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pg_fin,
    input  logic [ARR_AW-1:0]    pg_idx,
    input  logic [15:0]          pg_mask,
    input  logic                 er_fin,
    input  logic                 er_chip,
    input  logic [SECT_BITS-1:0] er_sect,
    input  logic [ARR_AW-1:0]    rd_idx,
    input  logic                 rd_lane,
    input  logic                 byte_mode,
    input  logic                 autosel,
    input  logic                 rd_busy,
    output logic [15:0]          rdata
);
    localparam int WORDS = 1 << ARR_AW;
    localparam int OFF_W = ARR_AW - SECT_BITS;

    logic [15:0]          cells [WORDS];
    logic [15:0]          word_rd;
    logic [SECT_BITS-1:0] rd_sect;
    logic [OFF_W-1:0]     rd_off;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        localparam int SI = i >> OFF_W;
        logic [15:0] cell_q;
        logic        hit_er;

        // Does the finishing erase cover this word
        always_comb begin
            hit_er = er_fin && (er_chip ? !PROT_MASK[SI]
                                        : (er_sect == SECT_BITS'(SI)));
        end

        // Cell update: erase wins over a program in the same cycle
        always_ff @(posedge clk) begin
            if (!rst_n)                       cell_q <= 16'hFFFF;
            else if (hit_er)                  cell_q <= 16'hFFFF;
            else if (pg_fin && pg_idx == ARR_AW'(i)) cell_q <= cell_q & pg_mask;
        end

        assign cells[i] = cell_q;

        if (PROT_MASK[SI]) begin : g_prot
            // R6
            prot_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> $stable(cell_q));
        end
    end

    assign word_rd = cells[rd_idx];
    assign rd_sect = rd_idx[ARR_AW-1 -: SECT_BITS];
    assign rd_off  = rd_idx[OFF_W-1:0];

    // Read mux: busy bank, autoselect protection word, byte or word data
    always_comb begin
        if (rd_busy)                             rdata = 16'h0000;
        else if (autosel && rd_off == OFF_W'(2)) rdata = {15'b0, PROT_MASK[rd_sect]};
        else if (byte_mode)                      rdata = {8'h00, rd_lane ? word_rd[15:8] : word_rd[7:0]};
        else                                     rdata = word_rd;
    end
endmodule

// File: rtl/nor_cmd_interp.sv
// Top: two-bank NOR command interpreter. Converts the bus address to a
// word index and lane, then wires decoder, engine and cell array.
// Assumes ADDR_W >= 12 and ADDR_W > ARR_AW; bank = top word-index bit.
module nor_cmd_interp #(
    parameter int                         ADDR_W    = 12,
    parameter int                         ARR_AW    = 8,
    parameter int                         SECT_BITS = 3,
    parameter logic [(1<<SECT_BITS)-1:0]  PROT_MASK = 8'b0000_0100,
    parameter int                         PROG_CYC  = 4,
    parameter int                         ERASE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              byte_mode,
    output logic [15:0]       rdata,
    output logic [1:0]        bank_busy,
    output logic              prog_start,
    output logic              erase_start
);
    logic [ARR_AW-1:0]    word_idx;
    logic                 lane;
    logic                 req_prog, req_serase, req_cerase, req_susp, req_resume;
    logic                 autosel;
    logic                 pg_fin, er_fin, er_chip;
    logic [ARR_AW-1:0]    pg_idx;
    logic [15:0]          pg_mask;
    logic [SECT_BITS-1:0] er_sect;

    // Word index and byte lane from the bus address
    always_comb begin
        word_idx = byte_mode ? addr[ARR_AW:1] : addr[ARR_AW-1:0];
        lane     = byte_mode && addr[0];
    end

    nfc_decoder #(.ADDR_W(ADDR_W)) i_dec (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .byte_mode(byte_mode), .req_prog(req_prog), .req_serase(req_serase),
        .req_cerase(req_cerase), .req_susp(req_susp), .req_resume(req_resume),
        .autosel(autosel)
    );

    nfc_engine #(
        .ARR_AW(ARR_AW), .SECT_BITS(SECT_BITS), .PROT_MASK(PROT_MASK),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) i_eng (
        .clk(clk), .rst_n(rst_n), .req_prog(req_prog), .req_serase(req_serase),
        .req_cerase(req_cerase), .req_susp(req_susp), .req_resume(req_resume),
        .tgt_idx(word_idx), .tgt_byte(byte_mode), .tgt_lane(lane),
        .tgt_data(wdata), .prog_start(prog_start), .erase_start(erase_start),
        .bank_busy(bank_busy), .pg_fin(pg_fin), .pg_idx(pg_idx),
        .pg_mask(pg_mask), .er_fin(er_fin), .er_chip(er_chip), .er_sect(er_sect)
    );

    nfc_array #(
        .ARR_AW(ARR_AW), .SECT_BITS(SECT_BITS), .PROT_MASK(PROT_MASK)
    ) i_arr (
        .clk(clk), .rst_n(rst_n), .pg_fin(pg_fin), .pg_idx(pg_idx),
        .pg_mask(pg_mask), .er_fin(er_fin), .er_chip(er_chip), .er_sect(er_sect),
        .rd_idx(word_idx), .rd_lane(lane), .byte_mode(byte_mode),
        .autosel(autosel), .rd_busy(bank_busy[word_idx[ARR_AW-1]]),
        .rdata(rdata)
    );
endmodule

// File: tb/test_nor_cmd_interp.sv
module test_nor_cmd_interp;
    localparam int         PC   = 4;
    localparam int         EC   = 16;
    localparam logic [7:0] PROT = 8'b0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] rdata;
    logic [1:0]  bank_busy;
    logic        prog_start, erase_start;

    int          n_chk = 0;
    int          n_err = 0;
    logic [15:0] exp_mem [256];

    always #4 clk = ~clk;

    nor_cmd_interp #(
        .ADDR_W(12), .ARR_AW(8), .SECT_BITS(3), .PROT_MASK(PROT),
        .PROG_CYC(PC), .ERASE_CYC(EC)
    ) i_nor_cmd_interp (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .byte_mode(byte_mode), .rdata(rdata), .bank_busy(bank_busy),
        .prog_start(prog_start), .erase_start(erase_start)
    );

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 16'h0123) ^ 16'hC3A5;
    endfunction

    function automatic logic is_prot(input int w);
        return PROT[w >> 5];
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] expv, input string tag);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic unlock();
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
    endtask

    task automatic rd(input logic [11:0] a, input logic bm, output logic [15:0] v);
        addr = a; byte_mode = bm; #1; v = rdata; byte_mode = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 1000 && bank_busy != 2'b00; g++) @(negedge clk);
    endtask

    task automatic sweep(input string tag);
        logic [15:0] v;
        for (int i = 0; i < 256; i++) begin
            rd(12'(i), 1'b0, v);
            chk(v, exp_mem[i], tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n;
        for (int i = 0; i < 256; i++) exp_mem[i] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({14'b0, bank_busy}, 16'h0, "R1 busy");
        chk({15'b0, prog_start | erase_start}, 16'h0, "R1 start pulses");
        sweep("R1 erased array");
        rd(12'h013, 1'b1, v); chk(v, 16'h00FF, "R1 byte read");

        // R8 bypass sweep programs every word; R6 protected sector stays
        unlock(); wr(12'h555, 16'h0020);
        for (int i = 0; i < 256; i++) begin
            wr(12'h000, 16'h00A0);
            wr(12'(i), pat(i));
            chk({15'b0, prog_start}, {15'b0, !is_prot(i)}, "R8/R6 bypass launch");
            wait_idle();
            if (!is_prot(i)) exp_mem[i] = exp_mem[i] & pat(i);
        end
        wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);
        sweep("R8 bypass data");
        wr(12'h000, 16'h00A0); wr(12'h010, 16'h0000);
        chk({15'b0, prog_start}, 16'h0, "R8 after exit no launch");
        wait_idle();
        rd(12'h010, 1'b0, v); chk(v, exp_mem[16], "R8 after exit data");

        // R3/R2 four-write program timing and AND behaviour
        unlock(); wr(12'h555, 16'h00A0); wr(12'h021, 16'h0F0F);
        chk({15'b0, prog_start}, 16'h1, "R3 start pulse");
        chk({14'b0, bank_busy}, 16'h1, "R3 busy first");
        for (int k = 1; k < PC; k++) begin
            @(negedge clk);
            if (k == 1) chk({15'b0, prog_start}, 16'h0, "R3 pulse width");
            chk({14'b0, bank_busy}, 16'h1, "R3 busy window");
        end
        @(negedge clk);
        chk({14'b0, bank_busy}, 16'h0, "R3 busy end");
        exp_mem[8'h21] = exp_mem[8'h21] & 16'h0F0F;
        rd(12'h021, 1'b0, v); chk(v, exp_mem[8'h21], "R2 AND result");

        // R2 byte-mode sequence to the upper lane of word 33h
        byte_mode = 1'b1;
        wr(12'hAAA, 16'h00AA); wr(12'h555, 16'h0055); wr(12'hAAA, 16'h00A0);
        wr(12'h067, 16'h003C);
        byte_mode = 1'b0;
        wait_idle();
        exp_mem[8'h33] = exp_mem[8'h33] & 16'h3CFF;
        rd(12'h067, 1'b1, v); chk(v, {8'h00, exp_mem[8'h33][15:8]}, "R2 byte upper");
        rd(12'h066, 1'b1, v); chk(v, {8'h00, exp_mem[8'h33][7:0]}, "R2 byte lower");

        // R10 mismatched cycles drop the sequence
        wr(12'h555, 16'h00AA); wr(12'h2AB, 16'h0055); wr(12'h555, 16'h00A0); wr(12'h010, 16'h0000);
        chk({15'b0, prog_start}, 16'h0, "R10 bad address");
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0054); wr(12'h555, 16'h00A0); wr(12'h011, 16'h0000);
        chk({15'b0, prog_start}, 16'h0, "R10 bad data");
        unlock(); wr(12'h556, 16'h00A0); wr(12'h012, 16'h0000);
        chk({15'b0, prog_start}, 16'h0, "R10 bad third address");
        wait_idle();
        rd(12'h010, 1'b0, v); chk(v, exp_mem[16], "R10 data kept");
        rd(12'h011, 1'b0, v); chk(v, exp_mem[17], "R10 data kept");
        rd(12'h012, 1'b0, v); chk(v, exp_mem[18], "R10 data kept");

        // R9 autoselect protection words
        unlock(); wr(12'h555, 16'h0090);
        for (int s = 0; s < 8; s++) begin
            rd(12'((s << 5) | 2), 1'b0, v); chk(v, {15'b0, PROT[s]}, "R9 protect word");
            rd(12'((s << 5) | 3), 1'b0, v); chk(v, exp_mem[(s << 5) | 3], "R9 other word");
        end
        rd(12'h084, 1'b1, v); chk(v, 16'h0001, "R9 byte offset 4");
        wr(12'h000, 16'h00F0);
        rd(12'h002, 1'b0, v); chk(v, exp_mem[2], "R9 exit by reset");

        // R4/R7 sector erase of sector 5 with the other bank readable
        unlock(); wr(12'h555, 16'h0080); unlock(); wr(12'h0A0, 16'h0030);
        chk({15'b0, erase_start}, 16'h1, "R4 erase pulse");
        for (int k = 0; k < EC; k++) begin
            chk({14'b0, bank_busy}, 16'h2, "R4 busy window");
            rd(12'h005, 1'b0, v); chk(v, exp_mem[5], "R7 idle bank data");
            rd(12'h0A3, 1'b0, v); chk(v, 16'h0000, "R7 busy bank zero");
            @(negedge clk);
        end
        chk({14'b0, bank_busy}, 16'h0, "R4 busy end");
        for (int i = 8'hA0; i < 8'hC0; i++) exp_mem[i] = 16'hFFFF;
        sweep("R4 after sector erase");

        // R6 erase of protected sector 2 dropped
        unlock(); wr(12'h555, 16'h0080); unlock(); wr(12'h040, 16'h0030);
        chk({15'b0, erase_start}, 16'h0, "R6 no erase pulse");
        chk({14'b0, bank_busy}, 16'h0, "R6 no busy");

        // R14 program during a running erase is dropped
        unlock(); wr(12'h555, 16'h0080); unlock(); wr(12'h0C0, 16'h0030);
        unlock(); wr(12'h555, 16'h00A0); wr(12'h005, 16'h0000);
        chk({15'b0, prog_start}, 16'h0, "R14 no launch while busy");
        wait_idle();
        for (int i = 8'hC0; i < 8'hE0; i++) exp_mem[i] = 16'hFFFF;
        rd(12'h005, 1'b0, v); chk(v, exp_mem[5], "R14 data kept");
        rd(12'h0C7, 1'b0, v); chk(v, 16'hFFFF, "R4 sector 6 erased");

        // R11/R12/R13 suspend and resume of a sector 1 erase
        unlock(); wr(12'h555, 16'h0080); unlock(); wr(12'h020, 16'h0030);
        repeat (2) @(negedge clk);
        wr(12'h000, 16'h00B0);
        chk({14'b0, bank_busy}, 16'h0, "R11 suspend drops busy");
        rd(12'h020, 1'b0, v); chk(v, exp_mem[8'h20], "R11 suspended sector readable");
        unlock(); wr(12'h555, 16'h00A0); wr(12'h060, 16'h00FF);
        chk({15'b0, prog_start}, 16'h1, "R13 program other sector");
        wait_idle();
        exp_mem[8'h60] = exp_mem[8'h60] & 16'h00FF;
        unlock(); wr(12'h555, 16'h00A0); wr(12'h021, 16'h0000);
        chk({15'b0, prog_start}, 16'h0, "R13 suspended sector dropped");
        wr(12'h000, 16'h00F0);
        chk({14'b0, bank_busy}, 16'h0, "R12 still suspended");
        wr(12'h000, 16'h0030);
        n = 0;
        while (bank_busy[0] && n < 100) begin n++; @(negedge clk); end
        chk(16'(n), 16'(EC - 4), "R11 remaining erase time");
        for (int i = 8'h20; i < 8'h40; i++) exp_mem[i] = 16'hFFFF;
        sweep("R13/R11 after resumed erase");

        // R5 chip erase; R11 suspend ignored during it
        unlock(); wr(12'h555, 16'h0080); unlock(); wr(12'h555, 16'h0010);
        chk({15'b0, erase_start}, 16'h1, "R5 chip erase pulse");
        chk({14'b0, bank_busy}, 16'h3, "R5 both banks busy");
        wr(12'h000, 16'h00B0);
        chk({14'b0, bank_busy}, 16'h3, "R11 no suspend of chip erase");
        wait_idle();
        for (int i = 0; i < 256; i++) exp_mem[i] = 16'hFFFF;
        sweep("R5 after chip erase");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule